// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serializer

This block turns a parallel pair of 16-bit two's-complement samples, one left and one right, into a single serial data line. Bits go out most significant first. The left word is always sent in the half-frame where the left/right clock is low, and the right word in the half-frame where it is high. Three static mode pins pick between four master and four slave modes. In a master mode the block makes the bit clock, the left/right clock and the word clock from its system clock. In a slave mode it takes the bit clock and the left/right clock from outside. The word clock is an input in exactly one slave mode and an output in every other mode.

Bit-clock cycles are called slots. Within each half-frame the slots are numbered 0 to 31, where slot 0 opens at the bit-clock falling edge that carries the left/right transition. Data and the word clock change only on falling bit-clock edges, and the receiver samples them on rising edges. The placement modes are right-justified, right-justified-plus-one, left-justified, I2S, and a slave mode where the placement follows the word-clock input.

Samples enter through a valid/ready port. `smp_ready` is a one-cycle pulse at the system-clock edge where the left half-frame opens. A pair is accepted in that cycle only if `smp_valid` is high. A producer that wants a pair used must therefore hold `smp_valid` and the data steady until it sees the pulse. No pair is buffered beyond the holding register.

Top module: `stereo_serializer_top`

## Requirements
- R1: Each channel word is 16 bits, sent MSB first, one bit per slot. The left word goes in the lrck-low half and the right word in the lrck-high half. `sdata_o` is 0 in every slot outside a word.
- R2: In master modes `bclk_o` has a period of 2*DIV system clocks. `lrck_o` starts at 1 after reset and toggles on every 32nd falling bit-clock edge, so 0 marks the left half.
- R3: Right-justified modes (slave=0 or 1, rj=1, dly=1) place the MSB in slot 16 and drive the word clock high in slots 16 to 31.
- R4: Master right-justified-plus-one mode (slave=0, rj=1, dly=0) drives the word clock high in slot 16 only. The MSB goes in slot 17, and the LSB lands in slot 0 of the following half-frame.
- R5: Left-justified modes (rj=0, dly=1) place the MSB in slot 0 and drive the word clock high in slots 0 to 15.
- R6: I2S modes (rj=0, dly=0) place the MSB in slot 1 and drive the word clock high in slots 1 to 16.
- R7: In word-clock-input mode (slave=1, rj=1, dly=0), the MSB goes in the slot after the first rising bit-clock edge of the half-frame at which `wclk_in` is seen high. The MSB is never placed in slot 0. Holding `wclk_in` high gives slot 1. `wclk_o` stays 0 in this mode.
- R8: `clk_oe` equals the inverse of `mode_slave`. `wclk_oe` is 0 only in the word-clock-input mode.
- R9: `smp_ready` pulses for one system clock as left slot 0 opens. Both words of that frame come from the pair accepted there. Data changes at any other time have no effect on the output.
- R10: If `smp_valid` is low at the ready pulse, the previous pair is sent again.
- R11: During and right after reset, `sdata_o`, `bclk_o`, `wclk_o` and `smp_ready` are 0 and `lrck_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_slave | input | 1 | 1 = slave, 0 = master |
| mode_rj | input | 1 | Placement select, right-side group |
| mode_dly | input | 1 | Placement select, delay bit |
| smp_left | input | 16 | Left sample |
| smp_right | input | 16 | Right sample |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Pair accept pulse |
| bclk_in | input | 1 | Bit clock in (slave) |
| lrck_in | input | 1 | Left/right clock in (slave) |
| wclk_in | input | 1 | Word clock in (word-clock-input mode) |
| bclk_o | output | 1 | Bit clock out (master) |
| lrck_o | output | 1 | Left/right clock out (master) |
| wclk_o | output | 1 | Word clock out |
| clk_oe | output | 1 | Drive enable for bit and left/right clock pads |
| wclk_oe | output | 1 | Drive enable for word clock pad |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions assume that the mode pins stay still while reset is released. They also assume that slave clocks are slow against the system clock: each bit-clock level lasts several system clocks, and `lrck_in` and `wclk_in` change only near falling bit-clock edges. The bench changes the mode only while reset is held. Its slave generator holds each bit-clock level for eight system clocks and moves the left/right and word clocks together with the falling edge. Sample data is changed only on the clock after a ready pulse, or while valid is low.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [2:0] {
    FMT_RJ   = 3'd0,
    FMT_RJP1 = 3'd1,
    FMT_LJ   = 3'd2,
    FMT_I2S  = 3'd3,
    FMT_WIN  = 3'd4
  } fmt_e;

  typedef struct packed {
    logic master;
    logic wclk_drive;
    fmt_e fmt;
  } mode_t;
endpackage

// File: rtl/ser_mode_dec.sv
module ser_mode_dec
  import ser_pkg::*;
(
  input  logic  slave_sel,
  input  logic  rj_sel,
  input  logic  dly_sel,
  output mode_t mode
);
  always_comb begin
    mode.master     = !slave_sel;
    mode.wclk_drive = 1'b1;
    mode.fmt        = FMT_RJ;
    unique case ({rj_sel, dly_sel})
      2'b11: mode.fmt = FMT_RJ;
      2'b10: begin
        mode.fmt        = slave_sel ? FMT_WIN : FMT_RJP1;
        mode.wclk_drive = !slave_sel;
      end
      2'b01: mode.fmt = FMT_LJ;
      default: mode.fmt = FMT_I2S;
    endcase
  end
endmodule

// File: rtl/ser_timebase.sv
module ser_timebase #(
  parameter int DIV   = 2,
  parameter int SLOTS = 32,
  parameter int SYNC  = 2,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          bclk_in,
  input  logic          lrck_in,
  input  logic          wclk_in,
  output logic          ev_fall,
  output logic          ev_rise,
  output logic [SW-1:0] slot_n,
  output logic          lr_n,
  output logic          lr_q,
  output logic          bclk_q,
  output logic          wclk_s
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  // master divider
  logic [CW-1:0] div_cnt;
  logic          bclk_r;
  logic          tc;
  assign tc = (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_r  <= 1'b0;
    end else if (master) begin
      if (tc) begin
        div_cnt <= '0;
        bclk_r  <= ~bclk_r;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // slave input synchronizers: {wclk, lrck, bclk}
  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    logic [2:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {wclk_in, lrck_in, bclk_in};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_sync[g-1].q;
      end
    end
  end

  logic [2:0] syn;
  logic       b_last;
  assign syn = g_sync[SYNC-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_last <= 1'b0;
    else        b_last <= syn[0];
  end

  assign ev_fall = master ? (tc & bclk_r)  : (b_last & ~syn[0]);
  assign ev_rise = master ? (tc & ~bclk_r) : (~b_last & syn[0]);

  // slot and half-frame tracking
  logic [SW-1:0] slot_q;
  logic          lr_r;
  logic          last;
  assign last = (slot_q == SW'(SLOTS - 1));

  always_comb begin
    if (master) begin
      slot_n = last ? '0 : slot_q + 1'b1;
      lr_n   = last ? ~lr_r : lr_r;
    end else begin
      lr_n   = syn[1];
      slot_n = (syn[1] != lr_r) ? '0 : (last ? slot_q : slot_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SW'(SLOTS - 1);
      lr_r   <= 1'b1;
    end else if (ev_fall) begin
      slot_q <= slot_n;
      lr_r   <= lr_n;
    end
  end

  assign lr_q   = lr_r;
  assign bclk_q = bclk_r;
  assign wclk_s = syn[2];

  // R2: half-frame boundary only moves with a falling bit-clock edge
  a_r2_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_r) |-> $past(ev_fall));

  // R2: in master modes every wrap of the slot count flips the half
  a_r2_half_len: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ev_fall && last) |=> (lr_r != $past(lr_r)));
endmodule

// File: rtl/ser_wclk_gen.sv
module ser_wclk_gen
  import ser_pkg::*;
#(
  parameter int W     = 16,
  parameter int SLOTS = 32,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          ev_fall,
  input  logic [SW-1:0] slot_n,
  output logic          wclk_o
);
  localparam logic [SW-1:0] RJ_S = SW'(SLOTS - W);
  localparam logic [SW-1:0] WEND = SW'(W);

  logic shape;
  always_comb begin
    unique case (fmt)
      FMT_RJ:   shape = (slot_n >= RJ_S);
      FMT_RJP1: shape = (slot_n == RJ_S);
      FMT_LJ:   shape = (slot_n < WEND);
      FMT_I2S:  shape = (slot_n != '0) && (slot_n <= WEND);
      default:  shape = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wclk_o <= 1'b0;
    else if (ev_fall) wclk_o <= shape;
  end

  // R3: the word clock moves only on falling bit-clock edges
  a_r3_wclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wclk_o) |-> $past(ev_fall));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_pkg::*;
#(
  parameter int W     = 16,
  parameter int SLOTS = 32,
  localparam int SW   = $clog2(SLOTS),
  localparam int CNTW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          ev_fall,
  input  logic          ev_rise,
  input  logic [SW-1:0] slot_n,
  input  logic          lr_n,
  input  logic          wclk_s,
  input  logic [W-1:0]  smp_left,
  input  logic [W-1:0]  smp_right,
  input  logic          smp_valid,
  output logic          smp_ready,
  output logic          sdata
);
  logic [SW-1:0] fix_start;
  always_comb begin
    unique case (fmt)
      FMT_RJ:   fix_start = SW'(SLOTS - W);
      FMT_RJP1: fix_start = SW'(SLOTS - W + 1);
      FMT_LJ:   fix_start = '0;
      default:  fix_start = SW'(1);
    endcase
  end

  logic [W-1:0]    hold_l, hold_r, word, sreg;
  logic [CNTW-1:0] cnt;
  logic            armed, wseen;
  logic            cap, take, start, win;

  assign win       = (fmt == FMT_WIN);
  assign cap       = ev_fall && (slot_n == '0) && !lr_n;
  assign take      = cap && smp_valid;
  assign smp_ready = cap;
  assign start     = ev_fall && (win ? (armed && wseen && (slot_n != '0))
                                     : (slot_n == fix_start));
  assign word      = lr_n ? hold_r : (take ? smp_left : hold_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (take) begin
      hold_l <= smp_left;
      hold_r <= smp_right;
    end
  end

  // word-clock detection for the input-framed mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      wseen <= 1'b0;
    end else begin
      if (ev_rise)      wseen <= wclk_s;
      else if (ev_fall) wseen <= 1'b0;
      if (ev_fall) begin
        if (slot_n == '0) armed <= 1'b1;
        else if (start)   armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      cnt   <= '0;
      sdata <= 1'b0;
    end else if (ev_fall) begin
      if (start) begin
        sdata <= word[W-1];
        sreg  <= word << 1;
        cnt   <= CNTW'(W - 1);
      end else if (cnt != '0) begin
        sdata <= sreg[W-1];
        sreg  <= sreg << 1;
        cnt   <= cnt - 1'b1;
      end else begin
        sdata <= 1'b0;
      end
    end
  end

  // R9: the accept window is a single system clock
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready);

  // R1: data line only moves on a falling bit-clock edge
  a_r1_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(ev_fall));

  // R1: once a word is finished and none starts, the line is quiet
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_fall) && !$past(start) && ($past(cnt) == '0)) |-> !sdata);
endmodule

// File: rtl/stereo_serializer_top.sv
module stereo_serializer_top
  import ser_pkg::*;
#(
  parameter int W     = 16,
  parameter int SLOTS = 32,
  parameter int DIV   = 2,
  parameter int SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_slave,
  input  logic         mode_rj,
  input  logic         mode_dly,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic         bclk_in,
  input  logic         lrck_in,
  input  logic         wclk_in,
  output logic         bclk_o,
  output logic         lrck_o,
  output logic         wclk_o,
  output logic         clk_oe,
  output logic         wclk_oe,
  output logic         sdata_o
);
  localparam int SW = $clog2(SLOTS);

  mode_t         mode;
  logic          ev_fall, ev_rise, lr_n, lr_q, bclk_q, wclk_s;
  logic [SW-1:0] slot_n;

  ser_mode_dec u_dec (
    .slave_sel (mode_slave),
    .rj_sel    (mode_rj),
    .dly_sel   (mode_dly),
    .mode      (mode)
  );

  ser_timebase #(.DIV(DIV), .SLOTS(SLOTS), .SYNC(SYNC)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (mode.master),
    .bclk_in (bclk_in),
    .lrck_in (lrck_in),
    .wclk_in (wclk_in),
    .ev_fall (ev_fall),
    .ev_rise (ev_rise),
    .slot_n  (slot_n),
    .lr_n    (lr_n),
    .lr_q    (lr_q),
    .bclk_q  (bclk_q),
    .wclk_s  (wclk_s)
  );

  ser_wclk_gen #(.W(W), .SLOTS(SLOTS)) u_wc (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt     (mode.fmt),
    .ev_fall (ev_fall),
    .slot_n  (slot_n),
    .wclk_o  (wclk_o)
  );

  ser_shifter #(.W(W), .SLOTS(SLOTS)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (mode.fmt),
    .ev_fall   (ev_fall),
    .ev_rise   (ev_rise),
    .slot_n    (slot_n),
    .lr_n      (lr_n),
    .wclk_s    (wclk_s),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .sdata     (sdata_o)
  );

  assign bclk_o  = bclk_q;
  assign lrck_o  = lr_q;
  assign clk_oe  = mode.master;
  assign wclk_oe = mode.wclk_drive;
endmodule

// File: tb/tb_stereo_serializer_top.sv
`timescale 1ns/1ps
module tb_stereo_serializer_top;
  localparam int DIV  = 2;
  localparam int H    = 8;
  localparam int NREC = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_slave = 1'b0, mode_rj = 1'b1, mode_dly = 1'b1;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic bclk_in = 1'b1, lrck_in = 1'b1, wclk_in = 1'b0;
  logic bclk_o, lrck_o, wclk_o, clk_oe, wclk_oe, sdata_o;

  always #2.5 clk = ~clk;

  stereo_serializer_top dut (
    .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave), .mode_rj(mode_rj),
    .mode_dly(mode_dly), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .bclk_in(bclk_in),
    .lrck_in(lrck_in), .wclk_in(wclk_in), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .wclk_o(wclk_o), .clk_oe(clk_oe), .wclk_oe(wclk_oe), .sdata_o(sdata_o)
  );

  int n_chk = 0, n_fail = 0;
  logic rec_d [NREC];
  logic rec_w [NREC];
  logic rec_l [NREC];
  logic [15:0] pl [3] = '{16'h8001, 16'h7FFE, 16'hA5C3};
  logic [15:0] pr [3] = '{16'h1234, 16'hFFFF, 16'h0F0F};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic feeder(input int skip);
    int nxt = 0;
    for (int f = 0; f < 3; f++) begin
      if (f == skip && skip > 0) begin
        smp_valid = 1'b0;
      end else begin
        smp_valid = 1'b1;
        smp_left  = pl[nxt];
        smp_right = pr[nxt];
        nxt++;
      end
      do @(negedge clk); while (!smp_ready);
      @(negedge clk);
      smp_valid = 1'b0;
      smp_left  = 16'h5AA5 ^ 16'(f * 77);   // R9: junk while a frame shifts
      smp_right = 16'hC33C ^ 16'(f * 13);
      repeat (100) @(negedge clk);
    end
  endtask

  task automatic rec_master();
    int i = 0, cyc = 0, last_rise = 0;
    bit prevb = 1'b0, started = 1'b0;
    while (i < NREC) begin
      @(negedge clk);
      cyc++;
      if (bclk_o && !prevb) begin
        if (!started && !lrck_o) started = 1'b1;
        if (started) begin
          rec_d[i] = sdata_o; rec_w[i] = wclk_o; rec_l[i] = lrck_o;
          if (i == 3) chk((cyc - last_rise) == 2 * DIV, "R2", "bclk period",
                          cyc - last_rise, 2 * DIV);
          i++;
        end
        last_rise = cyc;
      end
      prevb = bclk_o;
    end
  endtask

  task automatic gen_slave(input bit win_mode, input int win_l, input int win_r);
    int slot = 31;
    bit lr = 1'b1;
    for (int i = 0; i < NREC; i++) begin
      repeat (H) @(negedge clk);
      bclk_in = 1'b0;
      slot = (slot + 1) % 32;
      if (slot == 0) lr = ~lr;
      lrck_in = lr;
      wclk_in = win_mode && (slot >= (lr ? win_r : win_l));
      repeat (H) @(negedge clk);
      rec_d[i] = sdata_o; rec_w[i] = wclk_o; rec_l[i] = lr;
      bclk_in = 1'b1;
    end
  endtask

  // wm: 0 frames 16..31, 1 pulse at 16, 2 slots 0..15, 3 slots 1..16, 4 low
  task automatic run(input bit slv, input bit rj, input bit dly,
                     input int sl, input int sr, input int wm,
                     input int win_l, input int win_r, input int skip,
                     input string tag);
    rst_n = 1'b0;
    mode_slave = slv; mode_rj = rj; mode_dly = dly;
    bclk_in = 1'b1; lrck_in = 1'b1;
    wclk_in = slv && rj && !dly && (win_l == 0);
    smp_valid = 1'b1; smp_left = pl[0]; smp_right = pr[0];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(clk_oe == !slv, "R8", "clk_oe", clk_oe, !slv);
    chk(wclk_oe == !(slv && rj && !dly), "R8", "wclk_oe", wclk_oe,
        !(slv && rj && !dly));
    fork
      feeder(skip);
      if (slv) gen_slave(rj && !dly, win_l, win_r);
      else     rec_master();
    join
    for (int a = 0; a < NREC; a++) begin
      int s = a % 32;
      bit ed = 1'b0, ew;
      for (int f = 0; f < 3; f++) begin
        int pi = (skip > 0 && f >= skip) ? f - 1 : f;
        for (int c = 0; c < 2; c++) begin
          int b = f * 64 + c * 32 + (c ? sr : sl);
          logic [15:0] wd = c ? pr[pi] : pl[pi];
          if (a >= b && a < b + 16) ed = wd[15 - (a - b)];
        end
      end
      case (wm)
        0: ew = (s >= 16);
        1: ew = (s == 16);
        2: ew = (s < 16);
        3: ew = (s >= 1 && s <= 16);
        default: ew = 1'b0;
      endcase
      chk(rec_d[a] == ed, tag, $sformatf("data slot %0d", a), rec_d[a], ed);
      chk(rec_w[a] == ew, tag, $sformatf("wclk slot %0d", a), rec_w[a], ew);
      if (!slv) chk(rec_l[a] == ((a / 32) % 2), "R2",
                    $sformatf("lrck slot %0d", a), rec_l[a], (a / 32) % 2);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode_slave = 1'b0; mode_rj = 1'b1; mode_dly = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(sdata_o == 1'b0, "R11", "sdata", sdata_o, 0);
    chk(bclk_o == 1'b0, "R11", "bclk", bclk_o, 0);
    chk(lrck_o == 1'b1, "R11", "lrck", lrck_o, 1);
    chk(wclk_o == 1'b0, "R11", "wclk", wclk_o, 0);
    chk(smp_ready == 1'b0, "R11", "ready", smp_ready, 0);
  endtask

  task automatic t_master_rj();   run(0, 1, 1, 16, 16, 0, 0, 0, 0, "R3"); endtask
  task automatic t_master_rjp1(); run(0, 1, 0, 17, 17, 1, 0, 0, 0, "R4"); endtask
  task automatic t_master_lj();   run(0, 0, 1, 0, 0, 2, 0, 0, 0, "R5"); endtask
  task automatic t_master_i2s_underrun(); run(0, 0, 0, 1, 1, 3, 0, 0, 1, "R10"); endtask
  task automatic t_slave_rj();    run(1, 1, 1, 16, 16, 0, 0, 0, 0, "R3"); endtask
  task automatic t_slave_lj();    run(1, 0, 1, 0, 0, 2, 0, 0, 0, "R5"); endtask
  task automatic t_slave_i2s();   run(1, 0, 0, 1, 1, 3, 0, 0, 0, "R6"); endtask
  task automatic t_win_tied();    run(1, 1, 0, 1, 1, 4, 0, 0, 0, "R7"); endtask
  task automatic t_win_window();  run(1, 1, 0, 6, 11, 4, 5, 10, 2, "R7"); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_master_rj();
    t_master_rjp1();
    t_master_lj();
    t_master_i2s_underrun();  // R6 placement with R10 repeat and R9 junk
    t_slave_rj();
    t_slave_lj();
    t_slave_i2s();
    t_win_tied();
    t_win_window();           // R1 words in each half, R10 repeat
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule